// File: doc/BRIEF.md
# Snapshot 64-bit Time Counter

This block keeps a 64-bit count that advances by one on every edge of a slow clock. A host running on a separate, faster clock cannot read that count directly without the risk of tearing, so it reads it through a snapshot handshake. The host pulses an update request. The slow side latches the running count into a capture register on one of its next edges. The host side then copies that value into a pair of 32-bit output words and raises a valid flag, which also serves as the interrupt line.

The host waits for the valid flag, reads the low and high words, and drops the flag with a one-cycle clear strobe. While a request is in flight a pending flag is high. That flag clears itself when the snapshot arrives. Further requests made while it is high fold into the outstanding one. The two output words change only when a snapshot lands, so both halves always belong to the same capture.

Top module: `tsnap_timer`

## Requirements
- R1: While host reset is high, and on the first host cycle after it, valid and pending read 0 and both snapshot words read 0.
- R2: The count loads CNT_RST (default zero) during slow reset and then increases by exactly one on every slow-clock edge.
- R3: A request pulse while pending is low is accepted. On the next host cycle pending reads 1 and valid reads 0.
- R4: After an accepted request, valid rises and pending falls in the same host cycle. This happens no later than three slow-clock periods plus four host-clock cycles after the accepting edge.
- R5: The 64-bit snapshot {high word, low word} is not less than the count at the moment of the request and not greater than the count when valid is observed.
- R6: A request pulse while pending is high is merged. It produces no second capture, so after completion pending stays 0, valid stays 1 and the words do not change.
- R7: The snapshot words stay unchanged in every host cycle in which valid does not rise.
- R8: A clear pulse drops valid on the next host cycle and leaves the words unchanged. A clear pulse while valid is already low has no effect.
- R9: If a clear pulse and an arriving snapshot fall in the same host cycle, valid is set. With clear held high throughout, valid is therefore seen high for exactly one host cycle per snapshot.
- R10: The low word carries into the high word. A snapshot taken after the count passes 2^32 reads high word 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst | input | 1 | Host synchronous reset, active high |
| sclk | input | 1 | Slow counting clock |
| srst | input | 1 | Slow-domain synchronous reset, active high |
| upd_req_i | input | 1 | Update request pulse (host domain) |
| irq_clr_i | input | 1 | Clear pulse for the valid flag and interrupt |
| req_pending_o | output | 1 | Request accepted and not yet completed |
| valid_irq_o | output | 1 | Snapshot ready flag and interrupt line |
| snap_lo_o | output | WORD_W | Low word of the snapshot |
| snap_hi_o | output | WORD_W | High word of the snapshot |

## Verification
The hardest case to reach is a snapshot arriving in the very host cycle that carries a clear pulse. Its timing is set by two synchronizers and the phase of an unrelated clock. The bench avoids aiming at that cycle. Instead it holds the clear input high across a whole request, so the arrival cycle always coincides with a clear, and then checks that valid is seen high for exactly one cycle. Carry into the high word would take billions of slow cycles from zero, so the bench starts the count just below 2^32 by setting the reset value parameter.

// File: rtl/tsnap_pkg.sv
package tsnap_pkg;
  localparam int unsigned TSNAP_SYNC_DEF = 2;
  localparam int unsigned TSNAP_WORD_DEF = 32;

  typedef struct packed {
    logic pending;
    logic valid;
  } tsnap_flags_t;
endpackage

// File: rtl/tsnap_sync.sv
module tsnap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b0;
        else     s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tsnap_counter.sv
module tsnap_counter #(
  parameter int unsigned     CW      = 64,
  parameter logic [CW-1:0]   RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= RST_VAL;
    else     count <= count + {{(CW-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/tsnap_slow_capture.sv
module tsnap_slow_capture #(
  parameter int unsigned CW     = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic          sclk,
  input  logic          srst,
  input  logic          req_tog,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] cap_q,
  output logic          ack_tog
);
  logic req_s;
  logic req_prev_q;
  logic take;

  tsnap_sync #(.STAGES(STAGES)) u_req_sync (
    .clk (sclk),
    .rst (srst),
    .d   (req_tog),
    .q   (req_s)
  );

  assign take = req_s ^ req_prev_q;

  always_ff @(posedge sclk) begin
    if (srst) begin
      req_prev_q <= 1'b0;
      cap_q      <= '0;
      ack_tog    <= 1'b0;
    end else begin
      req_prev_q <= req_s;
      if (take) begin
        cap_q   <= count;
        ack_tog <= ~ack_tog;
      end
    end
  end
endmodule

// File: rtl/tsnap_host_ctrl.sv
module tsnap_host_ctrl #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned STAGES = 2,
  localparam int unsigned CW    = 2 * WORD_W
) (
  input  logic              hclk,
  input  logic              hrst,
  input  logic              upd_req,
  input  logic              irq_clr,
  input  logic              ack_tog,
  input  logic [CW-1:0]     cap_q,
  output logic              req_tog,
  output tsnap_pkg::tsnap_flags_t flags,
  output logic [WORD_W-1:0] snap_lo,
  output logic [WORD_W-1:0] snap_hi
);
  logic ack_s;
  logic ack_prev_q;
  logic arrive;
  logic accept;

  tsnap_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk (hclk),
    .rst (hrst),
    .d   (ack_tog),
    .q   (ack_s)
  );

  assign arrive = ack_s ^ ack_prev_q;
  assign accept = upd_req & ~flags.pending;

  always_ff @(posedge hclk) begin
    if (hrst) begin
      ack_prev_q    <= 1'b0;
      req_tog       <= 1'b0;
      flags.pending <= 1'b0;
      flags.valid   <= 1'b0;
      snap_lo       <= '0;
      snap_hi       <= '0;
    end else begin
      ack_prev_q <= ack_s;
      if (accept) begin
        req_tog       <= ~req_tog;
        flags.pending <= 1'b1;
      end else if (arrive) begin
        flags.pending <= 1'b0;
      end
      // set has priority over clear
      if (arrive)                  flags.valid <= 1'b1;
      else if (accept || irq_clr)  flags.valid <= 1'b0;
      if (arrive) begin
        snap_lo <= cap_q[WORD_W-1:0];
        snap_hi <= cap_q[CW-1:WORD_W];
      end
    end
  end
endmodule

// File: rtl/tsnap_timer.sv
module tsnap_timer #(
  parameter int unsigned           WORD_W      = tsnap_pkg::TSNAP_WORD_DEF,
  parameter int unsigned           SYNC_STAGES = tsnap_pkg::TSNAP_SYNC_DEF,
  parameter logic [2*WORD_W-1:0]   CNT_RST     = '0
) (
  input  logic              hclk,
  input  logic              hrst,
  input  logic              sclk,
  input  logic              srst,
  input  logic              upd_req_i,
  input  logic              irq_clr_i,
  output logic              req_pending_o,
  output logic              valid_irq_o,
  output logic [WORD_W-1:0] snap_lo_o,
  output logic [WORD_W-1:0] snap_hi_o
);
  localparam int unsigned CNT_W = 2 * WORD_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic             req_tog;
  logic             ack_tog;
  tsnap_pkg::tsnap_flags_t flags;

  tsnap_counter #(.CW(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
    .clk   (sclk),
    .rst   (srst),
    .count (cnt_q)
  );

  tsnap_slow_capture #(.CW(CNT_W), .STAGES(SYNC_STAGES)) u_cap (
    .sclk    (sclk),
    .srst    (srst),
    .req_tog (req_tog),
    .count   (cnt_q),
    .cap_q   (cap_q),
    .ack_tog (ack_tog)
  );

  tsnap_host_ctrl #(.WORD_W(WORD_W), .STAGES(SYNC_STAGES)) u_host (
    .hclk    (hclk),
    .hrst    (hrst),
    .upd_req (upd_req_i),
    .irq_clr (irq_clr_i),
    .ack_tog (ack_tog),
    .cap_q   (cap_q),
    .req_tog (req_tog),
    .flags   (flags),
    .snap_lo (snap_lo_o),
    .snap_hi (snap_hi_o)
  );

  assign req_pending_o = flags.pending;
  assign valid_irq_o   = flags.valid;
endmodule

// File: rtl/tsnap_timer_chk.sv
module tsnap_timer_chk #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CW    = 2 * WORD_W
) (
  input logic              hclk,
  input logic              hrst,
  input logic              sclk,
  input logic              srst,
  input logic              upd_req_i,
  input logic              irq_clr_i,
  input logic              req_pending_o,
  input logic              valid_irq_o,
  input logic [WORD_W-1:0] snap_lo_o,
  input logic [WORD_W-1:0] snap_hi_o,
  input logic [CW-1:0]     cnt
);
  // R1
  reset_state_chk: assert property (@(posedge hclk)
    hrst |=> (!valid_irq_o && !req_pending_o && snap_lo_o == '0 && snap_hi_o == '0));

  // R2
  count_step_chk: assert property (@(posedge sclk) disable iff (srst)
    !$past(srst) |-> (cnt == CW'($past(cnt) + 1'b1)));

  // R4
  valid_rise_chk: assert property (@(posedge hclk) disable iff (hrst)
    (!$past(hrst) && $rose(valid_irq_o)) |-> ($past(req_pending_o) && !req_pending_o));

  // R6
  pending_drop_chk: assert property (@(posedge hclk) disable iff (hrst)
    (!$past(hrst) && $fell(req_pending_o)) |-> $rose(valid_irq_o));

  // R7
  snap_stable_chk: assert property (@(posedge hclk) disable iff (hrst)
    (!$past(hrst) && !$rose(valid_irq_o)) |-> ($stable(snap_lo_o) && $stable(snap_hi_o)));

  // R8
  valid_fall_chk: assert property (@(posedge hclk) disable iff (hrst)
    (!$past(hrst) && $fell(valid_irq_o)) |-> ($past(irq_clr_i) || $past(upd_req_i)));
endmodule

bind tsnap_timer tsnap_timer_chk #(.WORD_W(WORD_W)) u_chk (
  .hclk          (hclk),
  .hrst          (hrst),
  .sclk          (sclk),
  .srst          (srst),
  .upd_req_i     (upd_req_i),
  .irq_clr_i     (irq_clr_i),
  .req_pending_o (req_pending_o),
  .valid_irq_o   (valid_irq_o),
  .snap_lo_o     (snap_lo_o),
  .snap_hi_o     (snap_hi_o),
  .cnt           (cnt_q)
);

// File: tb/tsnap_timer_tb.sv
`timescale 1ns/1ps
module tsnap_timer_tb;
  localparam int unsigned W       = 32;
  localparam logic [63:0] RST_V   = 64'h0000_0000_FFFF_FFA0;
  localparam int          LAT_MAX = (3 * 74 + 4 * 8) / 8;

  logic hclk = 1'b0, sclk = 1'b0;
  logic hrst = 1'b1, srst = 1'b1;
  logic upd = 1'b0, clr = 1'b0;
  logic pend, valid;
  logic [W-1:0] lo, hi;

  int nchk = 0, nbad = 0;
  bit done = 1'b0;
  logic [63:0] model;

  tsnap_timer #(.WORD_W(W), .CNT_RST(RST_V)) u_dut (
    .hclk (hclk), .hrst (hrst), .sclk (sclk), .srst (srst),
    .upd_req_i (upd), .irq_clr_i (clr),
    .req_pending_o (pend), .valid_irq_o (valid),
    .snap_lo_o (lo), .snap_hi_o (hi)
  );

  always #4 hclk = ~hclk;
  initial begin #1; forever #37 sclk = ~sclk; end

  // expected slow count per the requirement: reset value plus edges since reset
  always @(posedge sclk) model <= srst ? RST_V : model + 64'd1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge hclk);
  endtask

  // one request; extra keeps the request high a second cycle (merged)
  task automatic snapshot(input bit extra, output logic [63:0] got);
    logic [63:0] m0, m1;
    int n;
    m0 = model;
    upd = 1'b1;
    @(negedge hclk);
    upd = extra;
    chk(pend && !valid, "R3 pending set, valid cleared", {62'd0, pend, valid}, 64'd2);
    @(negedge hclk);
    upd = 1'b0;
    n = 1;
    while (!valid && n < 80) begin @(negedge hclk); n++; end
    m1 = model;
    chk(valid && !pend, "R4 valid up, pending down", {62'd0, pend, valid}, 64'd1);
    chk(n <= LAT_MAX, "R4 latency", 64'(n), 64'(LAT_MAX));
    got = {hi, lo};
    chk(got >= m0 && got <= m1, "R2 R5 snapshot within count window", got, m0);
    if (extra) begin
      bit ok = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge hclk);
        if (pend || !valid || {hi, lo} != got) ok = 1'b0;
      end
      chk(ok, "R6 merged request", {hi, lo}, got);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [63:0] s, prev;
    void'($urandom(32'd4242));
    idle(12);
    chk(!pend && !valid && lo == '0 && hi == '0, "R1 reset state",
        {pend, valid, lo, hi[W-3:0]}, 64'd0);
    hrst = 1'b0; srst = 1'b0;
    @(negedge hclk);
    chk(!pend && !valid && lo == '0 && hi == '0, "R1 first cycle after reset",
        {pend, valid, lo, hi[W-3:0]}, 64'd0);

    // first snapshot: just below the carry
    snapshot(1'b0, s);
    chk(s[63:32] == 32'd0, "R10 high word before carry", s, RST_V);

    // R8 clear keeps words
    prev = {hi, lo};
    clr = 1'b1; @(negedge hclk); clr = 1'b0;
    chk(!valid && {hi, lo} == prev, "R8 clear drops valid", {63'd0, valid}, 64'd0);
    clr = 1'b1; @(negedge hclk); clr = 1'b0;
    idle(3);
    chk(!valid && !pend && {hi, lo} == prev, "R8 clear while low has no effect", {hi, lo}, prev);

    // pass the carry point
    idle(1200);
    chk({hi, lo} == prev, "R7 words stable without request", {hi, lo}, prev);
    snapshot(1'b0, s);
    chk(s[63:32] == 32'd1 && s[31:0] < 32'd2000, "R10 carry into high word", s, 64'h1_0000_0000);

    // R6 directed merge
    snapshot(1'b1, s);

    // R9 clear held across arrival
    begin
      logic [63:0] m0, m1;
      int hits;
      hits = 0;
      m1 = '0;
      clr = 1'b1;
      m0 = model;
      upd = 1'b1; @(negedge hclk); upd = 1'b0;
      for (int i = 0; i < 60; i++) begin
        @(negedge hclk);
        if (valid) begin hits++; m1 = model; end
      end
      clr = 1'b0;
      chk(hits == 1, "R9 set wins over clear", 64'(hits), 64'd1);
      chk({hi, lo} >= m0 && {hi, lo} <= m1, "R5 snapshot under held clear", {hi, lo}, m0);
    end

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      int gap;
      bit ex, cl;
      gap = $urandom_range(0, 150);
      ex  = 1'($urandom_range(0, 1));
      cl  = 1'($urandom_range(0, 1));
      prev = {hi, lo};
      if (cl) begin clr = 1'b1; @(negedge hclk); clr = 1'b0; end
      idle(gap);
      chk({hi, lo} == prev, "R7 stable across gap", {hi, lo}, prev);
      snapshot(ex, s);
      chk(s > prev, "R2 count advanced between snapshots", s, prev);
    end

    done = 1'b1;
    summary();
  end
endmodule